// File: doc/BRIEF.md
# Peak Bandwidth Monitor Unit

This block watches a set of memory-bus ports and measures how much data they move over repeating measurement windows. A programmable prescaler divides the bus clock into a time-base tick, and a window lasts a programmable number of ticks. For every port, and for the sum of all ports, the block keeps a per-window accumulator. At each window boundary the window total is compared with a stored peak, and the larger value is retained. Software therefore reads the busiest single window seen since the counters were last cleared, not a running sum.

Counting can be done in bytes, KiB or MiB. Bytes that do not yet make up a whole unit are kept in a residue register. That residue carries across beats and across windows, so coarse units lose no traffic. Counters saturate instead of wrapping. Turning the monitor on from the off state clears every counter. While it is off, all values hold and stay readable. Software uses the peak total against the nominal bandwidth of the current memory clock to decide whether to raise or lower that clock.

Top module: `bwmon_peak`

## Requirements
- R1: After reset the configuration register, the prescaler register, every per-port counter and the total counter all read as zero.
- R2: The prescaler register (address 0x04) holds N-1 and produces a tick every N bus clock cycles. A window spans (period field + 1) ticks, where the period field is bits [31:16] of the configuration register (address 0x00).
- R3: At each window boundary, a counter takes the larger of its stored peak and the just-ended window total. Beats accepted in the boundary cycle belong to the ending window. A later, smaller window leaves the peak unchanged.
- R4: Configuration bits [2:1] select the unit: 0 counts bytes, 1 counts KiB (1024 bytes), 2 counts MiB (1048576 bytes), and 3 counts bytes. Sub-unit remainders are carried across beats and windows.
- R5: Writing the configuration register with bit 0 set while bit 0 is clear clears all counters, the peaks and the timebase. Beats in that write cycle are dropped. Rewriting bit 0 as 1 while it is already set clears nothing.
- R6: While bit 0 is clear, beats are ignored, no window advances, and all counters hold their values and remain readable.
- R7: Window accumulators and peaks saturate at all-ones (2^CNT_W-1) and never wrap.
- R8: Port n's peak counter reads at 0x20+4n and counts only that port's beats. The total counter reads at 0x20+4*NPORTS and counts the sum of all ports' bytes. The configuration register reads back with only bits [31:16] and [2:0] kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte address |
| reg_rdata | output | 32 | Register read data, combinational from reg_raddr |
| beat_vld | input | NPORTS | Per-port transfer-valid strobe |
| beat_bytes | input | NPORTS*BYTES_W | Per-port byte count of the beat, port n at bits [n*BYTES_W +: BYTES_W] |

## Verification
The bench builds the block with two ports, 16-bit beat byte counts, 12-bit counters and an 8-bit prescaler. The 12-bit counters let three beats drive a counter into saturation. The 16-bit byte counts let 32 beats of 32768 bytes complete exactly one MiB inside a 64-cycle window. With two ports, the bench can show that the per-port counters and the summed total advance independently. A prescaler of 3 with a two-tick window, under a continuous stream of beats, gives an exact peak of 8 beats regardless of phase. That confirms the tick spacing.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;

   typedef enum logic [1:0] {
      UNIT_BYTE = 2'd0,
      UNIT_KIB  = 2'd1,
      UNIT_MIB  = 2'd2,
      UNIT_ALT  = 2'd3
   } unit_e;

   localparam logic [7:0]  ADDR_CFG      = 8'h00;
   localparam logic [7:0]  ADDR_PRESC    = 8'h04;
   localparam logic [7:0]  ADDR_CNT_BASE = 8'h20;
   localparam logic [31:0] CFG_KEEP_MASK = 32'hFFFF_0007;
   localparam int          RESIDUE_W     = 20;

   function automatic int unsigned unit_shift(unit_e u);
      case (u)
         UNIT_KIB: return 10;
         UNIT_MIB: return 20;
         default:  return 0;
      endcase
   endfunction

endpackage

// File: rtl/bwmon_timebase.sv
module bwmon_timebase #(
   parameter int TICK_W = 16,
   parameter int WIN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              run_i,
   input  logic [TICK_W-1:0] presc_i,
   input  logic [WIN_W-1:0]  period_i,
   output logic              win_end_o
);

   logic [TICK_W-1:0] presc_cnt_q;
   logic [WIN_W-1:0]  win_cnt_q;
   logic              tick;

   always_comb begin
      tick      = run_i && (presc_cnt_q >= presc_i);
      win_end_o = tick && (win_cnt_q >= period_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         presc_cnt_q <= '0;
         win_cnt_q   <= '0;
      end else if (run_i) begin
         presc_cnt_q <= tick ? '0 : presc_cnt_q + 1'b1;
         if (tick)
            win_cnt_q <= win_end_o ? '0 : win_cnt_q + 1'b1;
      end
   end

   // R2
   presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clr_i && !tick) |=> presc_cnt_q == $past(presc_cnt_q) + 1'b1);

   // R2
   win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clr_i && tick && !win_end_o) |=> win_cnt_q == $past(win_cnt_q) + 1'b1);

   // R6
   tb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clr_i) |=> $stable(presc_cnt_q) && $stable(win_cnt_q));

endmodule

// File: rtl/bwmon_win_acc.sv
module bwmon_win_acc
   import bwmon_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             vld_i,
   input  logic [IN_W-1:0]  bytes_i,
   input  unit_e            unit_i,
   input  logic             win_end_i,
   output logic [CNT_W-1:0] peak_o
);

   localparam int SUM_W  = ((IN_W > RESIDUE_W) ? IN_W : RESIDUE_W) + 1;
   localparam int WIDE_W = ((CNT_W > SUM_W) ? CNT_W : SUM_W) + 1;
   localparam logic [WIDE_W-1:0] CNT_MAX = WIDE_W'({CNT_W{1'b1}});

   logic [RESIDUE_W-1:0] res_q;
   logic [CNT_W-1:0]     acc_q, peak_q;
   logic [SUM_W-1:0]     sum, whole, frac_mask;
   logic [WIDE_W-1:0]    wide;
   logic [CNT_W-1:0]     win_total, win_max;

   always_comb begin
      sum       = SUM_W'(res_q) + SUM_W'(bytes_i);
      whole     = sum >> unit_shift(unit_i);
      frac_mask = (SUM_W'(1) << unit_shift(unit_i)) - SUM_W'(1);
      wide      = WIDE_W'(acc_q) + (vld_i ? WIDE_W'(whole) : '0);
      win_total = (wide > CNT_MAX) ? '1 : wide[CNT_W-1:0];
      win_max   = (win_total > peak_q) ? win_total : peak_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         res_q  <= '0;
         acc_q  <= '0;
         peak_q <= '0;
      end else if (run_i) begin
         if (vld_i)
            res_q <= RESIDUE_W'(sum & frac_mask);
         if (win_end_i) begin
            peak_q <= win_max;
            acc_q  <= '0;
         end else begin
            acc_q  <= win_total;
         end
      end
   end

   assign peak_o = peak_q;

   // R3
   peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> peak_q >= $past(peak_q));

   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (peak_q == '0) && (acc_q == '0) && (res_q == '0));

   // R6
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clr_i) |=> $stable(peak_q) && $stable(acc_q) && $stable(res_q));

   // R7
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clr_i && !win_end_i) |=> acc_q >= $past(acc_q));

   // R3
   win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clr_i && win_end_i) |=> acc_q == '0);

endmodule

// File: rtl/bwmon_peak.sv
module bwmon_peak
   import bwmon_pkg::*;
#(
   parameter int NPORTS  = 4,
   parameter int BYTES_W = 16,
   parameter int CNT_W   = 32,
   parameter int TICK_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_we,
   input  logic [7:0]                reg_waddr,
   input  logic [31:0]               reg_wdata,
   input  logic [7:0]                reg_raddr,
   output logic [31:0]               reg_rdata,
   input  logic [NPORTS-1:0]         beat_vld,
   input  logic [NPORTS*BYTES_W-1:0] beat_bytes
);

   localparam int         SUMB_W     = BYTES_W + $clog2(NPORTS + 1);
   localparam int         WIN_W      = 16;
   localparam logic [7:0] ADDR_TOTAL = ADDR_CNT_BASE + 8'(4 * NPORTS);

   if (NPORTS < 1 || (32 + 4 * NPORTS) > 252) begin : g_bad_ports
      $error("bwmon_peak: NPORTS out of range");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("bwmon_peak: CNT_W must be 1..32");
   end
   if (TICK_W < 1 || TICK_W > 32) begin : g_bad_tick
      $error("bwmon_peak: TICK_W must be 1..32");
   end
   if (BYTES_W < 1 || BYTES_W > 30) begin : g_bad_bytes
      $error("bwmon_peak: BYTES_W must be 1..30");
   end

   logic [31:0]       cfg_q;
   logic [TICK_W-1:0] presc_q;
   logic              clr, win_end, total_vld;
   logic [SUMB_W-1:0] total_bytes;
   logic [CNT_W-1:0]  port_peak [NPORTS];
   logic [CNT_W-1:0]  total_peak;
   unit_e             unit;

   assign clr  = reg_we && (reg_waddr == ADDR_CFG) && reg_wdata[0] && !cfg_q[0];
   assign unit = unit_e'(cfg_q[2:1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         presc_q <= '0;
      end else if (reg_we) begin
         if (reg_waddr == ADDR_CFG)
            cfg_q <= reg_wdata & CFG_KEEP_MASK;
         if (reg_waddr == ADDR_PRESC)
            presc_q <= reg_wdata[TICK_W-1:0];
      end
   end

   always_comb begin
      total_bytes = '0;
      for (int i = 0; i < NPORTS; i++) begin
         if (beat_vld[i])
            total_bytes = total_bytes + SUMB_W'(beat_bytes[i*BYTES_W +: BYTES_W]);
      end
      total_vld = |beat_vld;
   end

   bwmon_timebase #(.TICK_W(TICK_W), .WIN_W(WIN_W)) u_timebase (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .run_i     (cfg_q[0]),
      .presc_i   (presc_q),
      .period_i  (cfg_q[31:16]),
      .win_end_o (win_end)
   );

   for (genvar g = 0; g < NPORTS; g++) begin : g_port
      bwmon_win_acc #(.IN_W(BYTES_W), .CNT_W(CNT_W)) u_acc (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr_i     (clr),
         .run_i     (cfg_q[0]),
         .vld_i     (beat_vld[g]),
         .bytes_i   (beat_bytes[g*BYTES_W +: BYTES_W]),
         .unit_i    (unit),
         .win_end_i (win_end),
         .peak_o    (port_peak[g])
      );
   end

   bwmon_win_acc #(.IN_W(SUMB_W), .CNT_W(CNT_W)) u_total (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .run_i     (cfg_q[0]),
      .vld_i     (total_vld),
      .bytes_i   (total_bytes),
      .unit_i    (unit),
      .win_end_i (win_end),
      .peak_o    (total_peak)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_raddr == ADDR_CFG)
         reg_rdata = cfg_q;
      if (reg_raddr == ADDR_PRESC)
         reg_rdata = 32'(presc_q);
      if (reg_raddr == ADDR_TOTAL)
         reg_rdata = 32'(total_peak);
      for (int i = 0; i < NPORTS; i++) begin
         if (reg_raddr == ADDR_CNT_BASE + 8'(4 * i))
            reg_rdata = 32'(port_peak[i]);
      end
   end

   // R5
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cfg_q[0]);

   // R8
   cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_waddr == ADDR_CFG) |=> (cfg_q & ~CFG_KEEP_MASK) == '0);

endmodule

// File: tb/test_bwmon_peak.sv
`timescale 1ns/1ps
module test_bwmon_peak;

   localparam int NP = 2;
   localparam int BW = 16;
   localparam int CW = 12;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_we = 1'b0;
   logic [7:0]     reg_waddr = '0;
   logic [31:0]    reg_wdata = '0;
   logic [7:0]     reg_raddr = '0;
   logic [31:0]    reg_rdata;
   logic [NP-1:0]  beat_vld = '0;
   logic [NP*BW-1:0] beat_bytes = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bwmon_peak #(.NPORTS(NP), .BYTES_W(BW), .CNT_W(CW), .TICK_W(8)) i_bwmon_peak (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .beat_vld(beat_vld), .beat_bytes(beat_bytes)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      reg_raddr = a;
      #0.5;
      v = reg_rdata;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic drive(logic [15:0] b0, logic [15:0] b1);
      beat_vld   = {1'b1, 1'b1};
      beat_bytes = {b1, b0};
      @(negedge clk);
   endtask

   task automatic idle(int n);
      beat_vld = '0; beat_bytes = '0;
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(int period, int unit, int presc);
      wr(8'h00, (32'(period) << 16) | (32'(unit) << 1));
      wr(8'h04, 32'(presc));
      wr(8'h00, (32'(period) << 16) | (32'(unit) << 1) | 32'd1);
   endtask

   task automatic expect3(string req, int p0, int p1, int tot);
      logic [31:0] v;
      rd(8'h20, v); chk({req, " port0"}, v, 32'(p0));
      rd(8'h24, v); chk({req, " port1"}, v, 32'(p1));
      rd(8'h28, v); chk({req, " total"}, v, 32'(tot));
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); chk("R1 cfg", v, 0);
      rd(8'h04, v); chk("R1 presc", v, 0);
      expect3("R1", 0, 0, 0);
   endtask

   task automatic t_peak();
      logic [31:0] v;
      setup(15, 0, 0);
      rd(8'h00, v); chk("R8 cfg readback", v, 32'h000F_0001);
      drive(10, 5); drive(20, 5); drive(30, 5); drive(40, 5); drive(50, 5);
      idle(20);
      expect3("R3 R8 burst", 150, 25, 175);
      drive(100, 0); idle(20);
      expect3("R3 smaller window", 150, 25, 175);
      drive(300, 200); idle(20);
      expect3("R3 larger window", 300, 200, 500);
   endtask

   task automatic t_disable();
      wr(8'h00, 32'h000F_0000);
      for (int i = 0; i < 5; i++) drive(1000, 1000);
      idle(40);
      expect3("R6 disabled hold", 300, 200, 500);
      wr(8'h00, 32'h000F_0001);
      expect3("R5 enable clears", 0, 0, 0);
      drive(50, 0); idle(20);
      expect3("R5 counts after clear", 50, 0, 50);
      wr(8'h00, 32'h000F_0001);
      expect3("R5 re-enable no clear", 50, 0, 50);
   endtask

   task automatic t_presc();
      setup(1, 0, 3);
      for (int i = 0; i < 20; i++) drive(1, 2);
      idle(20);
      expect3("R2 prescaled window", 8, 16, 24);
   endtask

   task automatic t_units();
      setup(15, 1, 0);
      beat_vld = 2'b01; beat_bytes = {16'd0, 16'd512}; @(negedge clk);
      beat_vld = 2'b01; beat_bytes = {16'd0, 16'd512}; @(negedge clk);
      idle(20);
      expect3("R4 KiB from halves", 1, 0, 1);
      setup(15, 0, 0);
      wr(8'h00, 32'h000F_0002);
      setup(15, 1, 0);
      drive(600, 1023); idle(20);
      drive(600, 0); idle(20);
      expect3("R4 residue across windows", 1, 0, 1);
      setup(63, 0, 0);
      wr(8'h00, 32'h003F_0004);
      setup(63, 2, 0);
      for (int i = 0; i < 32; i++) drive(16'd32768, 0);
      idle(70);
      expect3("R4 MiB", 1, 0, 1);
   endtask

   task automatic t_sat();
      wr(8'h00, 32'h000F_0000);
      setup(15, 0, 0);
      drive(2000, 0); drive(2000, 0); drive(2000, 0);
      idle(20);
      expect3("R7 saturate", 4095, 0, 4095);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_peak();
      t_disable();
      t_presc();
      t_units();
      t_sat();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule